// File: doc/BRIEF.md
# Data memory write snooper

This block sits beside the write port of a 16-bit data memory and watches the traffic on it without driving anything back. A program running on the attached processor reports its answer by storing a word to a reserved result address. It reports completion by storing any word to a reserved finish address. The snooper turns those two stores into plain outputs: a held copy of the last result word, and a completion flag. A bench or an automated grader can then read the answer directly instead of searching through memory contents.

Both reserved addresses are parameters. By default the result address is 0xFFFE and the finish address is 0xFFFF. The completion flag is sticky, so a slow observer cannot miss it. A separate one-cycle pulse marks each individual store to the finish address.

Top module: `mem_write_snooper`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0x0000 and both `done` and `done_pulse` become 0.
- R2: A rising edge with `mem_we` = 1 and `mem_addr` = 0xFFFE loads `mem_wdata` into `result`, visible from that edge on.
- R3: A rising edge with `mem_we` = 1 and `mem_addr` = 0xFFFF sets `done` to 1. `done` then stays 1 until a reset.
- R4: `done_pulse` is 1 for exactly the cycle after each edge that saw a store to 0xFFFF, and 0 in every other cycle. Back-to-back stores keep it high for one cycle per store.
- R5: Stores with `mem_we` = 1 to any address other than the two reserved ones leave `result`, `done` and `done_pulse` as they would be with no store.
- R6: With `mem_we` = 0, neither reserved address has any effect, whatever the address and data.
- R7: A store to the finish address does not change `result`. A store to the result address does not change `done`.
- R8: Reset takes priority over a store that is on the bus at the same edge, so the store is lost.
- R9: Each new store to the result address replaces the previous value, including after `done` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | input | 16 | Address on the memory write port |
| mem_wdata | input | 16 | Data on the memory write port |
| mem_we | input | 1 | Write enable qualifying the address and data |
| result | output | 16 | Last word stored to the result address |
| done | output | 1 | Sticky flag, set by a store to the finish address |
| done_pulse | output | 1 | One-cycle marker following each finish store |

## Verification
The main same-cycle collision is reset against a store. The bench holds `rst` high while a valid store to the result address is on the bus, and then expects `result` to read 0x0000 rather than the stored word. A second pair of events shares a cycle boundary: in back-to-back cycles, a result store directly precedes a finish store, and finish stores also repeat back to back. The bench judges each following cycle on three things: the result value, the level of `done`, and a `done_pulse` that stays high across the repeated stores without a gap.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    localparam int SNP_AW = 16;
    localparam int SNP_DW = 16;

    localparam logic [SNP_AW-1:0] SNP_RESULT_ADDR = 16'hFFFE;
    localparam logic [SNP_AW-1:0] SNP_FINISH_ADDR = 16'hFFFF;

    typedef struct packed {
        logic [SNP_DW-1:0] result;
        logic              done;
        logic              pulse;
    } snoop_state_t;

endpackage

// File: rtl/snoop_addr_match.sv
module snoop_addr_match
    import snoop_pkg::*;
#(
    parameter logic [SNP_AW-1:0] MATCH_ADDR = SNP_RESULT_ADDR
) (
    input  logic [SNP_AW-1:0] addr,
    input  logic              we,
    output logic              hit
);

    logic addr_eq;

    always_comb begin
        addr_eq = (addr == MATCH_ADDR);
        hit     = we & addr_eq;
    end

endmodule

// File: rtl/snoop_state.sv
module snoop_state
    import snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_hit,
    input  logic              fin_hit,
    input  logic [SNP_DW-1:0] wdata,
    output logic [SNP_DW-1:0] result,
    output logic              done,
    output logic              done_pulse
);

    snoop_state_t st_d;
    snoop_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (cap_hit) begin
            st_d.result = wdata;
        end
        if (fin_hit) begin
            st_d.done = 1'b1;
        end
        st_d.pulse = fin_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result     = st_q.result;
    assign done       = st_q.done;
    assign done_pulse = st_q.pulse;

    // R2 / R9: a capture store is visible after the edge
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> (result == $past(wdata)));

    // R5 / R6 / R7: without a capture store the result holds
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cap_hit |=> $stable(result));

    // R3: the completion flag never drops outside reset
    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R3: a finish store raises the flag
    assert_done_set_R3: assert property (@(posedge clk) disable iff (rst)
        fin_hit |=> done);

    // R4: the pulse follows each finish store and nothing else
    assert_pulse_follow_R4: assert property (@(posedge clk) disable iff (rst)
        fin_hit |=> done_pulse);
    assert_pulse_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !fin_hit |=> !done_pulse);

    // R7: the flag stays clear until a finish store arrives
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!done && !fin_hit) |=> !done);

    // R1 / R8: reset clears everything whatever the bus carries
    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (result == '0 && !done && !done_pulse));

endmodule

// File: rtl/mem_write_snooper.sv
module mem_write_snooper
    import snoop_pkg::*;
#(
    parameter logic [SNP_AW-1:0] RESULT_ADDR = SNP_RESULT_ADDR,
    parameter logic [SNP_AW-1:0] FINISH_ADDR = SNP_FINISH_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SNP_AW-1:0] mem_addr,
    input  logic [SNP_DW-1:0] mem_wdata,
    input  logic              mem_we,
    output logic [SNP_DW-1:0] result,
    output logic              done,
    output logic              done_pulse
);

    localparam int N_WATCH = 2;
    localparam logic [SNP_AW-1:0] WATCH_ADDR [N_WATCH] = '{RESULT_ADDR, FINISH_ADDR};

    logic [N_WATCH-1:0] hit;

    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        snoop_addr_match #(
            .MATCH_ADDR (WATCH_ADDR[g])
        ) u_match (
            .addr (mem_addr),
            .we   (mem_we),
            .hit  (hit[g])
        );
    end

    snoop_state u_state (
        .clk        (clk),
        .rst        (rst),
        .cap_hit    (hit[0]),
        .fin_hit    (hit[1]),
        .wdata      (mem_wdata),
        .result     (result),
        .done       (done),
        .done_pulse (done_pulse)
    );

    // R5 / R6: with distinct reserved addresses at most one match fires
    always_comb begin
        if (RESULT_ADDR != FINISH_ADDR) begin
            assert_single_match_R5: assert ($onehot0(hit));
        end
    end

endmodule

// File: tb/mem_write_snooper_test.sv
module mem_write_snooper_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] result;
    logic        done;
    logic        done_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mem_write_snooper uut (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .result     (result),
        .done       (done),
        .done_pulse (done_pulse)
    );

    // vector: we, addr, data, expected result, expected done, expected pulse
    localparam int NV = 12;
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 16'hFFFE, 16'h1234, 16'h1234, 1'b0, 1'b0},  // R2
        {1'b0, 16'hFFFE, 16'hAAAA, 16'h1234, 1'b0, 1'b0},  // R6
        {1'b1, 16'h0032, 16'h5555, 16'h1234, 1'b0, 1'b0},  // R5
        {1'b1, 16'hFFFD, 16'h7777, 16'h1234, 1'b0, 1'b0},  // R5
        {1'b1, 16'hFFFE, 16'h00FF, 16'h00FF, 1'b0, 1'b0},  // R9
        {1'b0, 16'hFFFF, 16'h0000, 16'h00FF, 1'b0, 1'b0},  // R6
        {1'b1, 16'hFFFF, 16'h0002, 16'h00FF, 1'b1, 1'b1},  // R3 R7
        {1'b0, 16'h0000, 16'h0000, 16'h00FF, 1'b1, 1'b0},  // R4
        {1'b1, 16'hFFFE, 16'hBEEF, 16'hBEEF, 1'b1, 1'b0},  // R9 R7
        {1'b1, 16'hFFFF, 16'h1111, 16'hBEEF, 1'b1, 1'b1},  // R4
        {1'b1, 16'hFFFF, 16'h2222, 16'hBEEF, 1'b1, 1'b1},  // R4
        {1'b1, 16'h0000, 16'h0000, 16'hBEEF, 1'b1, 1'b0}   // R5
    };

    function automatic string vec_tag(int i);
        case (i)
            0:       return "R2";
            1, 5:    return "R6";
            2, 3, 11: return "R5";
            4:       return "R9";
            6:       return "R3";
            8:       return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string req, logic [15:0] er, logic ed, logic ep);
        n_checks++;
        if (result !== er || done !== ed || done_pulse !== ep) begin
            n_fail++;
            $display("FAIL %s: result=%h done=%b pulse=%b, expected result=%h done=%b pulse=%b",
                     req, result, done, done_pulse, er, ed, ep);
        end
    endtask

    task automatic drive(logic r, logic we, logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        rst       = r;
        mem_we    = we;
        mem_addr  = a;
        mem_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        drive(1'b1, 1'b0, 16'h0000, 16'h0000);
        drive(1'b1, 1'b0, 16'h0000, 16'h0000);
        check("R1", 16'h0000, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b0, VEC[i][50], VEC[i][49:34], VEC[i][33:18]);
            check(vec_tag(i), VEC[i][17:2], VEC[i][1], VEC[i][0]);
        end

        // R8: reset collides with a result store and with a finish store
        drive(1'b1, 1'b1, 16'hFFFE, 16'h9999);
        check("R8", 16'h0000, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 16'hFFFF, 16'h0001);
        check("R8", 16'h0000, 1'b0, 1'b0);

        // R3: flag survives long idle, cleared only by reset (R1)
        drive(1'b0, 1'b1, 16'hFFFF, 16'h0000);
        check("R3", 16'h0000, 1'b1, 1'b1);
        for (int k = 0; k < 20; k++) drive(1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
        check("R3", 16'h0000, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 16'h0000, 16'h0000);
        check("R1", 16'h0000, 1'b0, 1'b0);

        // R2: result store then finish store back to back
        drive(1'b0, 1'b1, 16'hFFFE, 16'hFFFF);
        check("R2", 16'hFFFF, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 16'hFFFF, 16'hDEAD);
        check("R7", 16'hFFFF, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 16'hFFFE, 16'h0000);
        check("R4", 16'hFFFF, 1'b1, 1'b0);

        finish_run();
    end

endmodule